// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block turns a single job request into the long chain of serial-flash commands that an erase or a program operation needs. A job is either an erase or a program. It carries a start address and a byte length. The block drives a command engine below it through a descriptor handshake. Each descriptor holds an opcode, a frame shape, an address, a data length, a data direction and the poll settings. The block also feeds that engine an outbound byte stream, and it takes back the status byte that ends each busy poll.

Each step of a job is an erase sector or a program page. For every step the sequencer sends a write-enable command and then the erase or program command. It then polls the status register until the busy flag drops, and only after that does it move on to the next step. Program data arrives on a ready/valid byte input. When the job has fewer bytes left than a page, the last page is filled up with zeros. The start address must sit on a sector boundary. A job that breaks this rule is rejected at once, and a job of zero length finishes at once without error. At the end of a program job the engine is handed a default read command, so that it goes back to memory-mapped reads.

Top module: `flash_job_seq`

## Requirements
- R1: Every erase or program command is preceded by a write-enable command: opcode 0x06, cmd_frame_o = 0 (opcode only), no output data phase, no polling.
- R2: An erase job sends one sector-erase command per sector: opcode 0x20, cmd_frame_o = 1 (opcode followed by 3 address bytes), cmd_dout_o = 0. The addresses are start + k*SECTOR_BYTES, and there are ceil(len/SECTOR_BYTES) of them, so a partial remainder still erases a whole sector.
- R3: A program job sends one page-program command per page: opcode 0x02, cmd_frame_o = 1, cmd_dout_o = 1, cmd_len_o = PAGE_BYTES. The addresses are start + k*PAGE_BYTES, and there are ceil(len/PAGE_BYTES) of them.
- R4: Each programmed page carries exactly PAGE_BYTES bytes on the wr stream. Job byte i (for i < len) comes from the input stream in arrival order, and every byte past len is 0x00. Exactly len input bytes are accepted per job.
- R5: After each erase or program command completes, a read-status command is sent: opcode 0x05, cmd_frame_o = 0, cmd_poll_o = 1, cmd_poll_bit_o = 0, cmd_poll_set_o = 0 (wait for bit 0 clear). When it completes, exactly one status byte is consumed through rd_ready_o. That byte never appears on the wr stream, and the next step starts only after it has been consumed.
- R6: A job whose address has any of its low log2(SECTOR_BYTES) bits set ends with done_o high in the cycle after start is sampled and err_o = 1. It sends no command and accepts no input byte. This check comes before the zero-length check.
- R7: An aligned zero-length job ends with done_o in the cycle after start is sampled, with err_o = 0, and sends no command.
- R8: A program job ends with one memory-mode command: opcode 0x03, cmd_frame_o = 1, cmd_mem_mode_o = 1, address field 0. The job does not wait for it to complete. An erase job sends no such command.
- R9: done_o is a single-cycle pulse, and err_o = 0 for a job that completes normally. A start asserted while a job is running is ignored.
- R10: Once cmd_valid_o rises, it and the whole descriptor hold steady until cmd_ready_i accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a job (sampled while idle) |
| op_i | input | 1 | Job kind: 0 erase, 1 program |
| addr_i | input | ADDR_W | Job start address |
| len_i | input | LEN_W | Job length in bytes |
| done_o | output | 1 | Job finished pulse |
| err_o | output | 2 | Result: 0 none, 1 misaligned |
| in_data_i | input | 8 | Program data byte |
| in_valid_i | input | 1 | Program data valid |
| in_ready_o | output | 1 | Program data accepted |
| cmd_valid_o | output | 1 | Descriptor valid |
| cmd_ready_i | input | 1 | Descriptor accepted |
| cmd_opcode_o | output | 8 | Flash opcode |
| cmd_frame_o | output | 1 | 0 opcode only, 1 opcode plus 3 address bytes |
| cmd_addr_o | output | ADDR_W | Address field |
| cmd_len_o | output | DLEN_W | Data phase length in bytes |
| cmd_dout_o | output | 1 | Data phase is outbound |
| cmd_poll_o | output | 1 | Repeat status read until condition |
| cmd_poll_bit_o | output | 3 | Status bit polled |
| cmd_poll_set_o | output | 1 | Poll ends when bit is 1 (else when 0) |
| cmd_mem_mode_o | output | 1 | Descriptor is the memory-mode read command |
| cmd_done_i | input | 1 | Engine finished the accepted command |
| wr_data_o | output | 8 | Outbound data byte |
| wr_valid_o | output | 1 | Outbound byte valid |
| wr_ready_i | input | 1 | Engine takes outbound byte |
| rd_valid_i | input | 1 | Status byte available |
| rd_ready_o | output | 1 | Status byte consumed and discarded |

## Verification
The bench builds the block with PAGE_BYTES = 16, SECTOR_BYTES = 64 and LEN_W = 16. With these values a job of a few dozen bytes spans several pages or sectors and ends in a partial page or sector. A misaligned address then only needs one of the low six bits set, and each job runs in a few hundred cycles. The engine model stalls the descriptor handshake and the input stream drops valid on some cycles, so hold behaviour and zero padding are both reached across page boundaries.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic {
        JOB_ERASE = 1'b0,
        JOB_PROG  = 1'b1
    } job_op_e;

    typedef enum logic {
        FRM_OPCODE   = 1'b0,
        FRM_OP_ADDR3 = 1'b1
    } frame_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_ALIGN = 2'd1
    } err_e;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_WREN,
        CK_ERASE,
        CK_PROG,
        CK_POLL,
        CK_MEMRD
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN_REQ,
        ST_WREN_WAIT,
        ST_MAIN_REQ,
        ST_FEED,
        ST_MAIN_WAIT,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_DRAIN,
        ST_MEM_REQ
    } seq_state_e;

    localparam logic [7:0] OPC_WREN       = 8'h06;
    localparam logic [7:0] OPC_SECT_ERASE = 8'h20;
    localparam logic [7:0] OPC_PAGE_PROG  = 8'h02;
    localparam logic [7:0] OPC_RD_STATUS  = 8'h05;
    localparam logic [7:0] OPC_READ       = 8'h03;
    localparam logic [2:0] BUSY_BIT       = 3'd0;

endpackage

// File: rtl/fsq_job_check.sv
module fsq_job_check #(
    parameter int ADDR_W       = 24,
    parameter int LEN_W        = 24,
    parameter int SECTOR_BYTES = 4096,
    localparam int ALIGN_BITS  = $clog2(SECTOR_BYTES)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              misaligned_o,
    output logic              empty_o
);
    always_comb begin
        misaligned_o = |addr_i[ALIGN_BITS-1:0];
        empty_o      = (len_i == '0);
    end
endmodule

// File: rtl/fsq_cmd_form.sv
module fsq_cmd_form
    import fsq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256,
    localparam int DLEN_W    = $clog2(PAGE_BYTES + 1)
) (
    input  cmd_kind_e         kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        opcode_o,
    output logic              frame_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DLEN_W-1:0] len_o,
    output logic              dout_o,
    output logic              poll_o,
    output logic [2:0]        poll_bit_o,
    output logic              poll_set_o,
    output logic              mem_mode_o
);
    always_comb begin
        opcode_o   = 8'h00;
        frame_o    = FRM_OPCODE;
        addr_o     = '0;
        len_o      = '0;
        dout_o     = 1'b0;
        poll_o     = 1'b0;
        poll_bit_o = 3'd0;
        poll_set_o = 1'b0;
        mem_mode_o = 1'b0;
        unique case (kind_i)
            CK_WREN: opcode_o = OPC_WREN;
            CK_ERASE: begin
                opcode_o = OPC_SECT_ERASE;
                frame_o  = FRM_OP_ADDR3;
                addr_o   = addr_i;
            end
            CK_PROG: begin
                opcode_o = OPC_PAGE_PROG;
                frame_o  = FRM_OP_ADDR3;
                addr_o   = addr_i;
                len_o    = DLEN_W'(PAGE_BYTES);
                dout_o   = 1'b1;
            end
            CK_POLL: begin
                opcode_o   = OPC_RD_STATUS;
                poll_o     = 1'b1;
                poll_bit_o = BUSY_BIT;
                poll_set_o = 1'b0;
            end
            CK_MEMRD: begin
                opcode_o   = OPC_READ;
                frame_o    = FRM_OP_ADDR3;
                mem_mode_o = 1'b1;
            end
            default: opcode_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/fsq_page_feed.sv
module fsq_page_feed #(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 24,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [LEN_W-1:0] rem_i,
    input  logic [7:0]       in_data_i,
    input  logic             in_valid_i,
    input  logic             wr_ready_i,
    output logic             in_ready_o,
    output logic             wr_valid_o,
    output logic [7:0]       wr_data_o,
    output logic             beat_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

    logic from_src;

    always_comb begin
        from_src   = ({{(LEN_W-IDX_W){1'b0}}, idx_i} < rem_i);
        wr_valid_o = en_i && (from_src ? in_valid_i : 1'b1);
        wr_data_o  = (en_i && from_src) ? in_data_i : 8'h00;
        in_ready_o = en_i && from_src && wr_ready_i;
        beat_o     = wr_valid_o && wr_ready_i;
        last_o     = (idx_i == LAST_IDX);
    end
endmodule

// File: rtl/flash_job_seq.sv
module flash_job_seq
    import fsq_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int LEN_W        = 24,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    localparam int DLEN_W      = $clog2(PAGE_BYTES + 1),
    localparam int IDX_W       = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              done_o,
    output logic [1:0]        err_o,
    input  logic [7:0]        in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [7:0]        cmd_opcode_o,
    output logic              cmd_frame_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DLEN_W-1:0] cmd_len_o,
    output logic              cmd_dout_o,
    output logic              cmd_poll_o,
    output logic [2:0]        cmd_poll_bit_o,
    output logic              cmd_poll_set_o,
    output logic              cmd_mem_mode_o,
    input  logic              cmd_done_i,
    output logic [7:0]        wr_data_o,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    input  logic              rd_valid_i,
    output logic              rd_ready_o
);
    localparam logic [LEN_W-1:0]  PAGE_L    = LEN_W'(PAGE_BYTES);
    localparam logic [LEN_W-1:0]  SECTOR_L  = LEN_W'(SECTOR_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_A    = ADDR_W'(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] SECTOR_A  = ADDR_W'(SECTOR_BYTES);

    typedef struct packed {
        seq_state_e        st;
        job_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [IDX_W-1:0]  idx;
        logic              done;
        err_e              err;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    cmd_kind_e kind;
    logic      issue;
    logic      feed_en;
    logic      drain;
    logic      misal, empty;
    logic      beat, last_beat;
    logic [LEN_W-1:0]  unit_len;
    logic [ADDR_W-1:0] unit_addr;

    fsq_job_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_check (
        .addr_i(addr_i), .len_i(len_i),
        .misaligned_o(misal), .empty_o(empty)
    );

    fsq_cmd_form #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_form (
        .kind_i(kind), .addr_i(s_q.addr),
        .opcode_o(cmd_opcode_o), .frame_o(cmd_frame_o),
        .addr_o(cmd_addr_o), .len_o(cmd_len_o), .dout_o(cmd_dout_o),
        .poll_o(cmd_poll_o), .poll_bit_o(cmd_poll_bit_o),
        .poll_set_o(cmd_poll_set_o), .mem_mode_o(cmd_mem_mode_o)
    );

    fsq_page_feed #(
        .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)
    ) u_feed (
        .en_i(feed_en), .idx_i(s_q.idx), .rem_i(s_q.rem),
        .in_data_i(in_data_i), .in_valid_i(in_valid_i),
        .wr_ready_i(wr_ready_i), .in_ready_o(in_ready_o),
        .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
        .beat_o(beat), .last_o(last_beat)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        kind      = CK_NONE;
        issue     = 1'b0;
        feed_en   = 1'b0;
        drain     = 1'b0;
        unit_len  = (s_q.op == JOB_PROG) ? PAGE_L : SECTOR_L;
        unit_addr = (s_q.op == JOB_PROG) ? PAGE_A : SECTOR_A;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.op   = job_op_e'(op_i);
                    s_d.addr = addr_i;
                    s_d.rem  = len_i;
                    s_d.err  = ERR_NONE;
                    if (misal) begin
                        s_d.done = 1'b1;
                        s_d.err  = ERR_ALIGN;
                    end else if (empty) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = ST_WREN_REQ;
                    end
                end
            end
            ST_WREN_REQ: begin
                kind  = CK_WREN;
                issue = 1'b1;
                if (cmd_ready_i) s_d.st = ST_WREN_WAIT;
            end
            ST_WREN_WAIT: begin
                if (cmd_done_i) s_d.st = ST_MAIN_REQ;
            end
            ST_MAIN_REQ: begin
                kind  = (s_q.op == JOB_PROG) ? CK_PROG : CK_ERASE;
                issue = 1'b1;
                if (cmd_ready_i) begin
                    s_d.idx = '0;
                    s_d.st  = (s_q.op == JOB_PROG) ? ST_FEED : ST_MAIN_WAIT;
                end
            end
            ST_FEED: begin
                feed_en = 1'b1;
                if (beat) begin
                    s_d.idx = s_q.idx + 1'b1;
                    if (last_beat) s_d.st = ST_MAIN_WAIT;
                end
            end
            ST_MAIN_WAIT: begin
                if (cmd_done_i) s_d.st = ST_POLL_REQ;
            end
            ST_POLL_REQ: begin
                kind  = CK_POLL;
                issue = 1'b1;
                if (cmd_ready_i) s_d.st = ST_POLL_WAIT;
            end
            ST_POLL_WAIT: begin
                if (cmd_done_i) s_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                drain = 1'b1;
                if (rd_valid_i) begin
                    if (s_q.rem <= unit_len) begin
                        s_d.rem = '0;
                        if (s_q.op == JOB_PROG) begin
                            s_d.st = ST_MEM_REQ;
                        end else begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                        end
                    end else begin
                        s_d.rem  = s_q.rem - unit_len;
                        s_d.addr = s_q.addr + unit_addr;
                        s_d.st   = ST_WREN_REQ;
                    end
                end
            end
            ST_MEM_REQ: begin
                kind  = CK_MEMRD;
                issue = 1'b1;
                if (cmd_ready_i) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, op: JOB_ERASE, addr: '0, rem: '0,
                     idx: '0, done: 1'b0, err: ERR_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_valid_o = issue;
    assign rd_ready_o  = drain;
    assign done_o      = s_q.done;
    assign err_o       = s_q.err;

    // Checker state: observes the command and data ports only.
    logic              chk_wren_armed_q;
    logic              chk_after_prog_q;
    logic              chk_cmd_seen_q;
    logic [DLEN_W:0]   chk_beats_q;
    logic              cmd_acc;

    assign cmd_acc = cmd_valid_o && cmd_ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_wren_armed_q <= 1'b0;
            chk_after_prog_q <= 1'b0;
            chk_cmd_seen_q   <= 1'b0;
            chk_beats_q      <= '0;
        end else begin
            if (start_i && s_q.st == ST_IDLE) chk_cmd_seen_q <= 1'b0;
            if (cmd_acc) begin
                chk_cmd_seen_q <= 1'b1;
                if (cmd_opcode_o == OPC_WREN) chk_wren_armed_q <= 1'b1;
                if (cmd_opcode_o == OPC_SECT_ERASE) begin
                    chk_wren_armed_q <= 1'b0;
                    chk_after_prog_q <= 1'b0;
                end
                if (cmd_opcode_o == OPC_PAGE_PROG) begin
                    chk_wren_armed_q <= 1'b0;
                    chk_after_prog_q <= 1'b1;
                    chk_beats_q      <= '0;
                end
            end else if (wr_valid_o && wr_ready_i) begin
                chk_beats_q <= chk_beats_q + 1'b1;
            end
        end
    end

    assert_wren_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && (cmd_opcode_o == OPC_SECT_ERASE || cmd_opcode_o == OPC_PAGE_PROG)
        |-> chk_wren_armed_q);

    assert_full_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_opcode_o == OPC_RD_STATUS && chk_after_prog_q
        |-> chk_beats_q == (DLEN_W+1)'(PAGE_BYTES));

    assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_o == ERR_ALIGN |-> !chk_cmd_seen_q);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i
        |=> cmd_valid_o && $stable(cmd_opcode_o) && $stable(cmd_addr_o)
            && $stable(cmd_mem_mode_o));

endmodule

// File: tb/sim_flash_job_seq.sv
`timescale 1ns/1ps
module sim_flash_job_seq;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = 16;
    localparam int PAGE   = 16;
    localparam int SECTOR = 64;
    localparam int DLEN_W = $clog2(PAGE + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              start = 1'b0;
    logic              op = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [LEN_W-1:0]  len = '0;
    logic              done_o;
    logic [1:0]        err_o;
    logic [7:0]        in_data;
    logic              in_valid;
    logic              in_ready;
    logic              cmd_valid, cmd_ready;
    logic [7:0]        cmd_opcode;
    logic              cmd_frame;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DLEN_W-1:0] cmd_len;
    logic              cmd_dout, cmd_poll, cmd_poll_set, cmd_mem;
    logic [2:0]        cmd_poll_bit;
    logic              cmd_done;
    logic [7:0]        wr_data;
    logic              wr_valid;
    logic              wr_ready;
    logic              rd_valid;
    logic              rd_ready;

    logic        clr_req = 1'b0;
    logic        stall_en = 1'b0;
    logic        bubble_en = 1'b0;
    logic [31:0] cyc;
    int          src_idx;
    int          in_taken;
    int          pops;
    int          hold_viol;
    logic        prev_pend;
    logic [7:0]  prev_opc;

    logic [7:0]        lg_opc [64];
    logic [ADDR_W-1:0] lg_addr [64];
    logic              lg_frame [64];
    logic [DLEN_W-1:0] lg_len [64];
    logic              lg_dout [64];
    logic              lg_poll [64];
    logic [2:0]        lg_pbit [64];
    logic              lg_pset [64];
    logic              lg_mem [64];
    int                lg_n;
    logic [7:0]        dl [256];
    int                dl_n;

    int   e_st;
    int   e_cnt;
    int   e_dly;
    logic e_poll;

    int n_chk = 0;
    int n_fail = 0;

    assign cmd_ready = !(stall_en && cyc[1:0] == 2'd0);
    assign in_valid  = !(bubble_en && (cyc % 5) == 2);
    assign in_data   = 8'((src_idx * 7 + 3) & 255);

    flash_job_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE), .SECTOR_BYTES(SECTOR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
        .len_i(len), .done_o(done_o), .err_o(err_o), .in_data_i(in_data),
        .in_valid_i(in_valid), .in_ready_o(in_ready), .cmd_valid_o(cmd_valid),
        .cmd_ready_i(cmd_ready), .cmd_opcode_o(cmd_opcode), .cmd_frame_o(cmd_frame),
        .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len), .cmd_dout_o(cmd_dout),
        .cmd_poll_o(cmd_poll), .cmd_poll_bit_o(cmd_poll_bit),
        .cmd_poll_set_o(cmd_poll_set), .cmd_mem_mode_o(cmd_mem),
        .cmd_done_i(cmd_done), .wr_data_o(wr_data), .wr_valid_o(wr_valid),
        .wr_ready_i(wr_ready), .rd_valid_i(rd_valid), .rd_ready_o(rd_ready)
    );

    // Command engine model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0; cmd_done <= 1'b0; wr_ready <= 1'b0; rd_valid <= 1'b0;
            e_st <= 0; e_cnt <= 0; e_dly <= 0; e_poll <= 1'b0;
            lg_n <= 0; dl_n <= 0; src_idx <= 0; in_taken <= 0; pops <= 0;
            hold_viol <= 0; prev_pend <= 1'b0; prev_opc <= 8'h00;
        end else begin
            cyc <= cyc + 1;
            cmd_done <= 1'b0;
            prev_pend <= cmd_valid && !cmd_ready;
            prev_opc  <= cmd_opcode;
            if (prev_pend && (!cmd_valid || cmd_opcode != prev_opc))
                hold_viol <= hold_viol + 1;
            if (clr_req) begin
                lg_n <= 0; dl_n <= 0; src_idx <= 0; in_taken <= 0; pops <= 0;
                hold_viol <= 0;
            end else begin
                if (in_valid && in_ready) begin
                    src_idx  <= src_idx + 1;
                    in_taken <= in_taken + 1;
                end
                if (cmd_valid && cmd_ready) begin
                    lg_opc[lg_n]   <= cmd_opcode;
                    lg_addr[lg_n]  <= cmd_addr;
                    lg_frame[lg_n] <= cmd_frame;
                    lg_len[lg_n]   <= cmd_len;
                    lg_dout[lg_n]  <= cmd_dout;
                    lg_poll[lg_n]  <= cmd_poll;
                    lg_pbit[lg_n]  <= cmd_poll_bit;
                    lg_pset[lg_n]  <= cmd_poll_set;
                    lg_mem[lg_n]   <= cmd_mem;
                    lg_n <= lg_n + 1;
                    if (!cmd_mem) begin
                        if (cmd_dout) begin
                            e_st <= 1; e_cnt <= 0; wr_ready <= 1'b1;
                        end else begin
                            e_st <= 2; e_dly <= 3; e_poll <= cmd_poll;
                        end
                    end
                end
                case (e_st)
                    1: if (wr_valid && wr_ready) begin
                        dl[dl_n] <= wr_data;
                        dl_n <= dl_n + 1;
                        if (e_cnt == PAGE - 1) begin
                            wr_ready <= 1'b0; e_st <= 2; e_dly <= 3; e_poll <= 1'b0;
                        end else begin
                            e_cnt <= e_cnt + 1;
                        end
                    end
                    2: if (e_dly == 0) begin
                        cmd_done <= 1'b1;
                        if (e_poll) begin
                            rd_valid <= 1'b1; e_st <= 3;
                        end else begin
                            e_st <= 0;
                        end
                    end else begin
                        e_dly <= e_dly - 1;
                    end
                    3: if (rd_valid && rd_ready) begin
                        rd_valid <= 1'b0; pops <= pops + 1; e_st <= 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_job(input logic o, input logic [ADDR_W-1:0] a,
                           input logic [LEN_W-1:0] l, input bit poke,
                           output int waited, output logic [1:0] e);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        start = 1'b1; op = o; addr = a; len = l;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done_o && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 6) begin
                start = 1'b1; op = 1'b1; addr = 24'h000400; len = 16'd5;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        e = err_o;
        chk(done_o == 1'b1, "R9", "job done seen", longint'(done_o), 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R9", "done single pulse", longint'(done_o), 0);
    endtask

    task automatic check_log(input logic o, input logic [ADDR_W-1:0] a,
                             input logic [LEN_W-1:0] l);
        int unit = o ? PAGE : SECTOR;
        int units = (int'(l) + unit - 1) / unit;
        int e = 0;
        for (int k = 0; k < units; k++) begin
            chk(lg_opc[e] == 8'h06 && lg_frame[e] == 1'b0 && !lg_dout[e] && !lg_poll[e]
                && !lg_mem[e], "R1", "write enable", longint'(lg_opc[e]), 64'h06);
            e++;
            if (o) begin
                chk(lg_opc[e] == 8'h02 && lg_frame[e] && lg_dout[e]
                    && lg_len[e] == DLEN_W'(PAGE), "R3", "page program",
                    longint'(lg_opc[e]), 64'h02);
            end else begin
                chk(lg_opc[e] == 8'h20 && lg_frame[e] && !lg_dout[e], "R2",
                    "sector erase", longint'(lg_opc[e]), 64'h20);
            end
            chk(lg_addr[e] == a + ADDR_W'(k * unit), o ? "R3" : "R2", "step address",
                longint'(lg_addr[e]), longint'(a + ADDR_W'(k * unit)));
            e++;
            chk(lg_opc[e] == 8'h05 && lg_frame[e] == 1'b0 && lg_poll[e]
                && lg_pbit[e] == 3'd0 && !lg_pset[e], "R5", "busy poll",
                longint'(lg_opc[e]), 64'h05);
            e++;
        end
        if (o) begin
            chk(lg_opc[e] == 8'h03 && lg_frame[e] && lg_mem[e] && lg_addr[e] == '0,
                "R8", "memory mode read", longint'(lg_opc[e]), 64'h03);
            e++;
        end
        chk(lg_n == e, o ? "R8" : "R2", "command count", lg_n, e);
        chk(pops == units, "R5", "status bytes consumed", pops, units);
        chk(hold_viol == 0, "R10", "descriptor held while stalled", hold_viol, 0);
        if (o) begin
            int bad = 0;
            chk(dl_n == units * PAGE, "R4", "bytes per page", dl_n, units * PAGE);
            for (int g = 0; g < units * PAGE; g++) begin
                logic [7:0] x = (g < int'(l)) ? 8'((g * 7 + 3) & 255) : 8'h00;
                if (dl[g] != x) bad++;
            end
            chk(bad == 0, "R4", "page data and zero pad", bad, 0);
            chk(in_taken == int'(l), "R4", "input bytes taken", in_taken, longint'(l));
        end else begin
            chk(dl_n == 0 && in_taken == 0, "R2", "no data phase", dl_n, 0);
        end
    endtask

    task automatic t_reset();
        chk(!done_o && !cmd_valid && !in_ready && !rd_ready && !wr_valid, "R9",
            "reset state", longint'({done_o, cmd_valid, in_ready, rd_ready}), 0);
    endtask

    task automatic t_erase(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                           input bit poke);
        int w; logic [1:0] e;
        run_job(1'b0, a, l, poke, w, e);
        chk(e == 2'd0, "R9", "erase no error", e, 0);
        check_log(1'b0, a, l);
        if (poke) chk(in_taken == 0, "R9", "start during job ignored", in_taken, 0);
    endtask

    task automatic t_prog(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l);
        int w; logic [1:0] e;
        run_job(1'b1, a, l, 1'b0, w, e);
        chk(e == 2'd0, "R9", "program no error", e, 0);
        check_log(1'b1, a, l);
    endtask

    task automatic t_reject(input logic o, input logic [ADDR_W-1:0] a,
                            input logic [LEN_W-1:0] l);
        int w; logic [1:0] e;
        run_job(o, a, l, 1'b0, w, e);
        chk(w == 0, "R6", "reject latency", w, 0);
        chk(e == 2'd1, "R6", "alignment error code", e, 1);
        chk(lg_n == 0 && in_taken == 0, "R6", "nothing sent", lg_n, 0);
    endtask

    task automatic t_empty();
        int w; logic [1:0] e;
        run_job(1'b1, 24'h000080, 16'd0, 1'b0, w, e);
        chk(w == 0, "R7", "empty job latency", w, 0);
        chk(e == 2'd0, "R7", "empty job no error", e, 0);
        chk(lg_n == 0, "R7", "empty job sends nothing", lg_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        stall_en = 1'b1; bubble_en = 1'b1;
        t_erase(24'h000040, 16'd130, 1'b0);
        t_erase(24'h001000, 16'd128, 1'b0);
        t_erase(24'h000000, 16'd1, 1'b0);
        t_prog(24'h000100, 16'd40);
        stall_en = 1'b0;
        t_prog(24'h000200, 16'd32);
        t_prog(24'h0003C0, 16'd3);
        bubble_en = 1'b0;
        t_prog(24'h000000, 16'd16);
        t_reject(1'b0, 24'h000041, 16'd10);
        t_reject(1'b1, 24'h000060, 16'd0);
        t_empty();
        stall_en = 1'b1;
        t_erase(24'h000040, 16'd130, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule